// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port. Software reaches it through a small synchronous register port.

Each pin has three pieces of state:
- an output value;
- a direction bit that enables the pad driver;
- a synchronized copy of the pad level, which software can read.

Every pin can also watch its pad for one of four trigger conditions. A detection sets a sticky status bit. Software clears that bit by writing a one to it. A per-pin mask selects which status bits feed the single interrupt line.

The register port uses a valid/ready request channel.
- `bus_ready` is always high, so a request is accepted in every cycle that `bus_valid` is high. The port never applies back-pressure.
- A write takes effect at the edge where it is accepted.
- A read returns its data on `rd_data` with `rd_valid` high exactly one cycle after it is accepted. The response cannot be stalled, so a requester must capture it in that cycle.

Pad inputs pass through a two-flop synchronizer before any detection logic sees them. Pad electrical control and pin multiplexing belong to the surrounding chip.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held and at the first clock after reset, `pad_out`, `pad_oe`, `irq` and `rd_valid` are all zero. All of the following registers reset to zero, so every pin starts as an input with its interrupt masked: output value, direction, both trigger words and mask.
- R2: The output-value register (offset 0x00) drives `pad_out`, and the direction register (offset 0x04) drives `pad_oe`. A direction bit of 1 makes the pin an output. Both registers read back what was written.
- R3: An accepted read (`bus_valid`=1, `bus_write`=0) produces `rd_valid`=1 with its data on the next cycle. In any other cycle `rd_valid` is 0. `bus_ready` is always 1.
- R4: The pad-level register (offset 0x08) is read-only. It returns each pad after two synchronizing flops: a pad value applied before edge k is seen by a read accepted at edge k+2. Writes to it are ignored.
- R5: Each pin has a 2-bit trigger code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
  - The word at offset 0x0C holds pins 0..15; pin n uses bits [2n+1:2n].
  - The word at offset 0x10 holds pins 16..31; pin 16+n uses bits [2n+1:2n].
- R6: A level trigger sets the pin's status bit at every edge where its synchronized level matches. An edge trigger compares the synchronized level with its value one cycle earlier.
- R7: Status bits (offset 0x18) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a clearing write and a new detection fall on the same edge, the status bit stays set.
- R9: The mask register (offset 0x14) reads back as written. `irq` is the OR over all pins of status AND mask, and it follows the registers without an extra cycle.
- R10: Reads from offsets that are not mapped (0x1C and above) return zero. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined masked interrupt |

## Verification
A write-one-to-clear on the status register can land on the same edge as a fresh detection for that bit. The bench provokes this by holding a high-level trigger active on pin 0 while it writes a clear to bit 0, with that pin unmasked. It then judges that both the read-back status and `irq` stay set. A reference model updated every clock checks every other cycle in which a clear and a rising or falling edge happen to meet.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] OFS_OUT   = 5'h00;
  localparam logic [AW-1:0] OFS_DIR   = 5'h04;
  localparam logic [AW-1:0] OFS_LVL   = 5'h08;
  localparam logic [AW-1:0] OFS_TRGLO = 5'h0C;
  localparam logic [AW-1:0] OFS_TRGHI = 5'h10;
  localparam logic [AW-1:0] OFS_MASK  = 5'h14;
  localparam logic [AW-1:0] OFS_STAT  = 5'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   sync_i,
  input  logic [2*W-1:0] code_i,
  output logic [W-1:0]   evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      trig_e kind;
      assign kind = trig_e'(code_i[2*i +: 2]);

      always_comb begin
        unique case (kind)
          TRIG_LOW:  evt_o[i] = ~sync_i[i];
          TRIG_HIGH: evt_o[i] = sync_i[i];
          TRIG_RISE: evt_o[i] = sync_i[i] & ~prev_q[i];
          TRIG_FALL: evt_o[i] = ~sync_i[i] & prev_q[i];
          default:   evt_o[i] = 1'b0;
        endcase
      end

      // R6
      rise_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[i] && kind == TRIG_RISE) |-> (sync_i[i] && !$past(sync_i[i])));
      // R6
      fall_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[i] && kind == TRIG_FALL) |-> (!sync_i[i] && $past(sync_i[i])));
    end
  endgenerate
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | evt_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_i);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));
  // R8
  detect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_i != '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic            rd_valid,
  output logic [PINS-1:0] rd_data,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq
);
  localparam int unsigned CODE_W = 2 * PINS;

  logic [PINS-1:0] out_q, dir_q, trg_lo_q, trg_hi_q, mask_q;
  logic [PINS-1:0] lvl, evt, status, clr;
  logic            wr_acc, rd_acc;

  assign bus_ready = 1'b1;
  assign wr_acc    = bus_valid & bus_write;
  assign rd_acc    = bus_valid & ~bus_write;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(lvl)
  );

  logic [CODE_W-1:0] codes;
  assign codes = {trg_hi_q, trg_lo_q};

  gpio_trigger #(.W(PINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .sync_i(lvl), .code_i(codes), .evt_o(evt)
  );

  assign clr = (wr_acc && bus_addr == OFS_STAT) ? bus_wdata : '0;

  gpio_status #(.W(PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
    .mask_i(mask_q), .status_o(status), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      trg_lo_q <= '0;
      trg_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr_acc) begin
      unique case (bus_addr)
        OFS_OUT:   out_q    <= bus_wdata;
        OFS_DIR:   dir_q    <= bus_wdata;
        OFS_TRGLO: trg_lo_q <= bus_wdata;
        OFS_TRGHI: trg_hi_q <= bus_wdata;
        OFS_MASK:  mask_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  logic [PINS-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      OFS_OUT:   rd_mux = out_q;
      OFS_DIR:   rd_mux = dir_q;
      OFS_LVL:   rd_mux = lvl;
      OFS_TRGLO: rd_mux = trg_lo_q;
      OFS_TRGHI: rd_mux = trg_hi_q;
      OFS_MASK:  rd_mux = mask_q;
      OFS_STAT:  rd_mux = status;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rd_mux;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  // R3
  read_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);
  // R3
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
  // R2
  oe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && bus_addr == OFS_DIR) |=> $stable(pad_oe));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic        bus_ready, rd_valid, irq;
  logic [31:0] rd_data, pad_out, pad_oe;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // behavioural reference model
  int          m_cfg [32];
  logic [31:0] m_s1, m_s2, m_prev, m_out, m_dir, m_mask, m_stat, m_rdd;
  logic        m_rdv;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] v = 0;
    case (a)
      5'h00: v = m_out;
      5'h04: v = m_dir;
      5'h08: v = m_s2;
      5'h0C: for (int p = 0; p < 16; p++) v[2*p +: 2] = m_cfg[p][1:0];
      5'h10: for (int p = 0; p < 16; p++) v[2*p +: 2] = m_cfg[p+16][1:0];
      5'h14: v = m_mask;
      5'h18: v = m_stat;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = 0; m_mask = 0;
      m_stat = 0; m_rdd = 0; m_rdv = 0;
      for (int p = 0; p < 32; p++) m_cfg[p] = 0;
    end else begin
      logic [31:0] hit = 0;
      for (int p = 0; p < 32; p++) begin
        case (m_cfg[p])
          0: hit[p] = !m_s2[p];
          1: hit[p] = m_s2[p];
          2: hit[p] = m_s2[p] && !m_prev[p];
          default: hit[p] = !m_s2[p] && m_prev[p];
        endcase
      end
      m_rdv = bus_valid && !bus_write;
      if (m_rdv) m_rdd = m_read(bus_addr);
      if (bus_valid && bus_write && bus_addr == 5'h18) m_stat = m_stat & ~bus_wdata;
      m_stat = m_stat | hit;
      if (bus_valid && bus_write) begin
        case (bus_addr)
          5'h00: m_out = bus_wdata;
          5'h04: m_dir = bus_wdata;
          5'h0C: for (int p = 0; p < 16; p++) m_cfg[p] = int'(bus_wdata[2*p +: 2]);
          5'h10: for (int p = 0; p < 16; p++) m_cfg[p+16] = int'(bus_wdata[2*p +: 2]);
          5'h14: m_mask = bus_wdata;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R2 pad_out", pad_out, m_out);
      chk("R2 pad_oe", pad_oe, m_dir);
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
      chk("R3 rd_valid", {31'b0, rd_valid}, {31'b0, m_rdv});
      chk("R3 bus_ready", {31'b0, bus_ready}, 32'd1);
      if (m_rdv) chk("R3 rd_data", rd_data, m_rdd);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    rd(5'h14, v); chk("R1 mask", v, 0);
    rd(5'h04, v); chk("R1 dir", v, 0);

    // R2
    wr(5'h00, 32'hA5A5_1234);
    wr(5'h04, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_1234);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h00, v); chk("R2 out readback", v, 32'hA5A5_1234);

    // R10 / R4 write ignored
    wr(5'h1C, 32'hDEAD_BEEF);
    rd(5'h1C, v); chk("R10 unmapped", v, 0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R4 write ignored", v, 0);

    // R4 synchronized level
    pad_in = 32'h1357_9BDF;
    idle(2);
    rd(5'h08, v); chk("R4 pad level", v, 32'h1357_9BDF);

    // R5 / R6 level-high on all pins
    wr(5'h0C, 32'h5555_5555);
    wr(5'h10, 32'h5555_5555);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R6 level high", v, 32'h1357_9BDF);

    // R5 rising on low half, falling on high half
    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hFFFF_FFFF);
    pad_in = 0;
    idle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R7 cleared", v, 0);
    pad_in = 32'hFFFF_FFFF;
    idle(4);
    rd(5'h18, v); chk("R5 rising low half", v, 32'h0000_FFFF);
    pad_in = 0;
    idle(4);
    rd(5'h18, v); chk("R5 falling high half", v, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0000_00FF);
    rd(5'h18, v); chk("R7 partial clear", v, 32'hFFFF_FF00);
    wr(5'h18, 32'h0);
    rd(5'h18, v); chk("R7 zero write", v, 32'hFFFF_FF00);

    // R9 mask and irq
    chk("R9 masked irq", {31'b0, irq}, 0);
    wr(5'h14, 32'h0000_0100);
    chk("R9 irq on", {31'b0, irq}, 1);
    rd(5'h14, v); chk("R9 mask readback", v, 32'h0000_0100);
    wr(5'h18, 32'h0000_0100);
    chk("R9 irq off", {31'b0, irq}, 0);

    // R8 clear collides with held level detection on pin 0
    wr(5'h0C, 32'hAAAA_AAA9);
    pad_in = 32'h1;
    idle(4);
    wr(5'h14, 32'h1);
    wr(5'h18, 32'h1);
    chk("R8 irq held", {31'b0, irq}, 1);
    rd(5'h18, v); chk("R8 status held", v & 32'h1, 32'h1);

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule